// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 24-bit virtual address to a 24-bit physical address by segmentation. The upper byte of the virtual address selects one of 256 segment descriptors. The lower sixteen bits are an offset into that segment. Each descriptor records whether it is present, which kinds of access it permits, how many bytes the segment spans and where the segment starts in physical memory. A valid request is answered one clock later with either a physical address (start plus offset) or a fault code.

Descriptors are loaded through a separate write port. A load and a lookup may happen in the same cycle. A lookup always sees the descriptor as it stood before that cycle's load. Missing-descriptor handling, paging and any translation caching belong to the surrounding system.

Top module: `segxl_top`

## Requirements
- R1: When `req_valid` is high at a rising clock edge, `rsp_valid` is high for the following cycle only. When `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are zero.
- R2: The segment index is `req_vaddr[23:16]` and the offset is `req_vaddr[15:0]`.
- R3: A request that raises no fault returns `rsp_fault` = 0 and `rsp_paddr` = descriptor start + offset, modulo 2^24.
- R4: A request whose descriptor has its present bit clear returns fault code 1. This fault outranks every other fault.
- R5: An offset greater than or equal to the descriptor's size returns fault code 2, so an offset equal to the size is rejected and a size of zero rejects every access. This fault outranks the permission fault.
- R6: Permission bit 0 allows read (kind 0), bit 1 allows write (kind 1) and bit 2 allows fetch (kind 2). Kind 3 is never allowed. A request whose kind is not allowed returns fault code 3.
- R7: `ld_en` loads descriptor `ld_index` at the clock edge. A request in the same cycle to the same index is answered from the previous contents, and requests in later cycles see the new contents.
- R8: After reset, `rsp_valid` is low and every descriptor is absent, so any request returns fault code 1 until its descriptor is loaded.
- R9: A faulting response drives `rsp_paddr` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 24 | Virtual address: segment index and offset |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| ld_en | input | 1 | Descriptor load strobe |
| ld_index | input | 8 | Descriptor to load |
| ld_present | input | 1 | Present bit to load |
| ld_perm | input | 3 | Permission bits to load (fetch, write, read) |
| ld_size | input | 16 | Segment size in bytes |
| ld_start | input | 24 | Segment start physical address |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 24 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 out of bounds, 3 permission |

## Verification
The two functions that can fall in the same cycle are a descriptor load and a lookup of that same descriptor. The bench provokes the overlap deliberately. It first loads an absent index while reading it, then narrows the permissions of a present descriptor while writing through it. Later it does so at random over a small set of indices, so that collisions occur often. The reference model computes each answer from its own table before it applies the cycle's load, and the answer must match the pre-load descriptor for that cycle and the new one from the next cycle on.

// File: rtl/segxl_pkg.sv
// Shared encodings for the segment translator.
// Assumes: two-bit access kinds and fault codes; permission bits indexed by kind.
package segxl_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_BOUNDS  = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    localparam int PERM_W = 3;
endpackage

// File: rtl/segxl_table.sv
// Descriptor storage: one present flop per entry (cleared by reset) and
// unreset storage for permissions, size and start. Reads are combinational
// from registered state, so a same-cycle load is seen only from the next cycle.
// Assumes: a single load port; the index is always in range (power-of-two depth).
module segxl_table #(
    parameter int SEG_W  = 8,
    parameter int DISP_W = 16,
    parameter int PA_W   = 24,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SEG_W-1:0]  ld_index,
    input  logic              ld_present,
    input  logic [PERM_W-1:0] ld_perm,
    input  logic [DISP_W-1:0] ld_size,
    input  logic [PA_W-1:0]   ld_start,
    input  logic [SEG_W-1:0]  rd_index,
    output logic              rd_present,
    output logic [PERM_W-1:0] rd_perm,
    output logic [DISP_W-1:0] rd_size,
    output logic [PA_W-1:0]   rd_start
);
    localparam int DEPTH = 1 << SEG_W;

    logic [DEPTH-1:0]  present_q;
    logic [PERM_W-1:0] perm_q  [DEPTH];
    logic [DISP_W-1:0] size_q  [DEPTH];
    logic [PA_W-1:0]   start_q [DEPTH];

    // One present flop per entry, cleared by reset.
    for (genvar e = 0; e < DEPTH; e++) begin : g_present
        always_ff @(posedge clk) begin  // hold or load this entry's present bit
            if (!rst_n)
                present_q[e] <= 1'b0;
            else if (ld_en && ld_index == SEG_W'(e))
                present_q[e] <= ld_present;
        end
    end

    always_ff @(posedge clk) begin  // load descriptor payload fields
        if (ld_en) begin
            perm_q[ld_index]  <= ld_perm;
            size_q[ld_index]  <= ld_size;
            start_q[ld_index] <= ld_start;
        end
    end

    always_comb begin  // read the addressed descriptor
        rd_present = present_q[rd_index];
        rd_perm    = perm_q[rd_index];
        rd_size    = size_q[rd_index];
        rd_start   = start_q[rd_index];
    end
endmodule

// File: rtl/segxl_check.sv
// Fault evaluation for one lookup. Priority: absent, then bounds, then permission.
// Assumes: the size is the segment length, so offset == size is out of bounds.
module segxl_check #(
    parameter int DISP_W = 16,
    parameter int PERM_W = 3
) (
    input  logic              present,
    input  logic [PERM_W-1:0] perm,
    input  logic [DISP_W-1:0] size,
    input  logic [DISP_W-1:0] offset,
    input  logic [1:0]        kind,
    output logic [1:0]        fault
);
    import segxl_pkg::*;

    logic allowed;

    always_comb begin  // pick the permission bit for this access kind
        unique case (acc_e'(kind))
            ACC_READ:  allowed = perm[0];
            ACC_WRITE: allowed = perm[1];
            ACC_FETCH: allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin  // prioritised fault code
        if (!present)
            fault = FLT_ABSENT;
        else if (offset >= size)
            fault = FLT_BOUNDS;
        else if (!allowed)
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/segxl_adder.sv
// Physical address formation: segment start plus zero-extended offset, wrapping.
// Assumes: PA_W >= DISP_W.
module segxl_adder #(
    parameter int DISP_W = 16,
    parameter int PA_W   = 24
) (
    input  logic [PA_W-1:0]   start,
    input  logic [DISP_W-1:0] offset,
    output logic [PA_W-1:0]   paddr
);
    always_comb begin  // modular sum of start and offset
        paddr = start + PA_W'(offset);
    end
endmodule

// File: rtl/segxl_top.sv
// Segment translator top: splits the virtual address, looks up the descriptor,
// evaluates faults, forms the address and registers the response one cycle later.
// Assumes: requests may come every cycle; no back-pressure.
module segxl_top #(
    parameter int SEG_W  = 8,
    parameter int DISP_W = 16,
    parameter int PA_W   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [SEG_W+DISP_W-1:0] req_vaddr,
    input  logic [1:0]              req_kind,
    input  logic                    ld_en,
    input  logic [SEG_W-1:0]        ld_index,
    input  logic                    ld_present,
    input  logic [2:0]              ld_perm,
    input  logic [DISP_W-1:0]       ld_size,
    input  logic [PA_W-1:0]         ld_start,
    output logic                    rsp_valid,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic [1:0]              rsp_fault
);
    import segxl_pkg::*;

    localparam int VA_W = SEG_W + DISP_W;

    logic [SEG_W-1:0]  seg_idx;
    logic [DISP_W-1:0] offset;
    logic              lk_present;
    logic [PERM_W-1:0] lk_perm;
    logic [DISP_W-1:0] lk_size;
    logic [PA_W-1:0]   lk_start;
    logic [1:0]        lk_fault;
    logic [PA_W-1:0]   lk_paddr;

    always_comb begin  // split the virtual address into index and offset
        seg_idx = req_vaddr[VA_W-1:DISP_W];
        offset  = req_vaddr[DISP_W-1:0];
    end

    segxl_table #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W), .PERM_W(PERM_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_index(ld_index), .ld_present(ld_present),
        .ld_perm(ld_perm), .ld_size(ld_size), .ld_start(ld_start),
        .rd_index(seg_idx), .rd_present(lk_present), .rd_perm(lk_perm),
        .rd_size(lk_size), .rd_start(lk_start)
    );

    segxl_check #(.DISP_W(DISP_W), .PERM_W(PERM_W)) u_check (
        .present(lk_present), .perm(lk_perm), .size(lk_size),
        .offset(offset), .kind(req_kind), .fault(lk_fault)
    );

    segxl_adder #(.DISP_W(DISP_W), .PA_W(PA_W)) u_adder (
        .start(lk_start), .offset(offset), .paddr(lk_paddr)
    );

    always_ff @(posedge clk) begin  // register the response; zero fields when idle or faulting
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid ? lk_fault : FLT_NONE;
            rsp_paddr <= (req_valid && lk_fault == FLT_NONE) ? lk_paddr : '0;
        end
    end
endmodule

// File: rtl/segxl_checks.sv
// Protocol and priority checks for segxl_top, attached by bind.
module segxl_checks #(
    parameter int DISP_W = 16,
    parameter int PA_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DISP_W-1:0] offset,
    input logic              lk_present,
    input logic [DISP_W-1:0] lk_size,
    input logic [PA_W-1:0]   lk_start,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [1:0]        rsp_fault
);
    a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'd0));
    a_r4_absent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lk_present) |=> rsp_fault == 2'd1);
    a_r5_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_present && offset >= lk_size) |=> rsp_fault == 2'd2);
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
    a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_present && offset < lk_size) |=>
            (rsp_fault != 2'd0 || rsp_paddr == $past(lk_start + PA_W'(offset))));
endmodule

bind segxl_top segxl_checks #(.DISP_W(DISP_W), .PA_W(PA_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .offset(offset),
    .lk_present(lk_present), .lk_size(lk_size), .lk_start(lk_start),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/segxl_top_test.sv
// Bench for segxl_top: behavioural reference table updated each clock,
// expected response compared with the outputs on every falling edge.
module segxl_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_index = '0;
    logic        ld_present = 1'b0;
    logic [2:0]  ld_perm = '0;
    logic [15:0] ld_size = '0;
    logic [23:0] ld_start = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    segxl_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .ld_en(ld_en), .ld_index(ld_index),
        .ld_present(ld_present), .ld_perm(ld_perm), .ld_size(ld_size),
        .ld_start(ld_start), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );

    // Reference table
    bit          m_present [256];
    logic [2:0]  m_perm    [256];
    int          m_size    [256];
    int          m_start   [256];

    bit          started = 0;
    logic        exp_valid = 0;
    int          exp_paddr = 0;
    int          exp_fault = 0;
    string       exp_tag = "R1";

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            exp_valid <= 0; exp_paddr <= 0; exp_fault <= 0; exp_tag <= "R8";
            foreach (m_present[i]) m_present[i] <= 0;
        end else begin
            int seg, off, f, pa;
            bit ok;
            seg = int'(req_vaddr[23:16]);   // R2: index in the upper byte
            off = int'(req_vaddr[15:0]);
            case (req_kind)
                2'd0: ok = m_perm[seg][0];
                2'd1: ok = m_perm[seg][1];
                2'd2: ok = m_perm[seg][2];
                default: ok = 0;
            endcase
            if (!m_present[seg]) f = 1;
            else if (off >= m_size[seg]) f = 2;
            else if (!ok) f = 3;
            else f = 0;
            pa = (f == 0) ? ((m_start[seg] + off) % (1 << 24)) : 0;
            exp_valid <= req_valid;
            exp_fault <= req_valid ? f : 0;
            exp_paddr <= req_valid ? pa : 0;
            if (req_valid && ld_en && ld_index == req_vaddr[23:16]) exp_tag <= "R7";
            else if (!req_valid) exp_tag <= "R1";
            else case (f)
                0: exp_tag <= "R2/R3";
                1: exp_tag <= "R4";
                2: exp_tag <= "R5";
                default: exp_tag <= "R6";
            endcase
            if (ld_en) begin
                m_present[ld_index] <= ld_present;
                m_perm[ld_index]    <= ld_perm;
                m_size[ld_index]    <= int'(ld_size);
                m_start[ld_index]   <= int'(ld_start);
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            compared++;
            if (rsp_valid !== exp_valid || rsp_fault !== 2'(exp_fault)
                || rsp_paddr !== 24'(exp_paddr)) begin
                mismatched++;
                $display("FAIL %s%s: got v=%0b f=%0d pa=%06h, expected v=%0b f=%0d pa=%06h",
                         exp_tag, (exp_fault != 0) ? " R9" : "",
                         rsp_valid, rsp_fault, rsp_paddr, exp_valid, exp_fault, exp_paddr);
            end
        end
    end

    task automatic req(input logic [7:0] seg, input logic [15:0] off, input logic [1:0] k);
        req_valid = 1; req_vaddr = {seg, off}; req_kind = k;
    endtask

    task automatic ld(input logic [7:0] idx, input logic p, input logic [2:0] pm,
                      input logic [15:0] sz, input logic [23:0] st);
        ld_en = 1; ld_index = idx; ld_present = p; ld_perm = pm; ld_size = sz; ld_start = st;
    endtask

    task automatic step();
        @(negedge clk);
        req_valid = 0; ld_en = 0;
    endtask

    task automatic report();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: run did not complete, got hang, expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: response idle during and right after reset
        compared++;
        if (rsp_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R8: got rsp_valid=%0b expected 0", rsp_valid);
        end
        rst_n = 1;
        // R8: every descriptor absent after reset
        req(8'd9, 16'h0000, 2'd0); step();
        // R1: idle gap
        step();
        // Descriptor loads
        ld(8'd1, 1, 3'b001, 16'h1000, 24'h100000); step();
        ld(8'd2, 1, 3'b100, 16'h2000, 24'hFFF000); step();
        ld(8'd3, 1, 3'b111, 16'h0000, 24'h000400); step();
        ld(8'd7, 0, 3'b111, 16'h0000, 24'h000000); step();
        // R3 / R5 on read-only segment: last in-bound offset, then offset == size
        req(8'd1, 16'h0FFF, 2'd0); step();
        req(8'd1, 16'h1000, 2'd0); step();
        // R6: write and fetch to read-only
        req(8'd1, 16'h0010, 2'd1); step();
        req(8'd1, 16'h0010, 2'd2); step();
        // R3: wrap modulo 2^24 on fetch-only segment
        req(8'd2, 16'h1800, 2'd2); step();
        req(8'd2, 16'h1800, 2'd0); step();            // R6
        req(8'd2, 16'h3000, 2'd1); step();            // R5 outranks R6
        req(8'd3, 16'h0000, 2'd0); step();            // R5 size zero
        req(8'd7, 16'h0005, 2'd3); step();            // R4 outranks bounds and perm
        // R7: load and lookup of the same index in one cycle
        ld(8'd4, 1, 3'b111, 16'hFFFF, 24'h000010); req(8'd4, 16'h0001, 2'd0); step();
        req(8'd4, 16'hFFFE, 2'd0); step();
        ld(8'd4, 1, 3'b001, 16'hFFFF, 24'h000010); req(8'd4, 16'h0020, 2'd1); step();
        req(8'd4, 16'h0020, 2'd1); step();            // R6 after narrowing
        req(8'd4, 16'h0020, 2'd3); step();            // R6 reserved kind
        // R7: removing a descriptor
        ld(8'd1, 0, 3'b001, 16'h1000, 24'h100000); req(8'd1, 16'h0000, 2'd0); step();
        req(8'd1, 16'h0000, 2'd0); step();            // R4
        // Random mix over a few indices
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 3) == 0)
                ld(8'($urandom_range(0, 7)), 1'($urandom_range(0, 4) != 0),
                   3'($urandom_range(0, 7)), 16'($urandom_range(0, 32)),
                   24'($urandom_range(0, 32'hFFFFFF)));
            if ($urandom_range(0, 4) != 0)
                req(8'($urandom_range(0, 7)), 16'($urandom_range(0, 34)),
                    2'($urandom_range(0, 3)));
            step();
        end
        step(); step();
        report();
    end
endmodule